// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a two-wire serial slave that owns a 21-byte configuration register file for a clock generator. The host reaches it over an SCL/SDA pair. The block drives SDA only by pulling it low, through an output-enable. Every register byte is also presented in parallel on a flat output bus so the rest of the chip can use the settings directly.

**Writes.** A write uses a fixed block sequence:

1. The write address.
2. A command byte, which is acknowledged and thrown away.
3. A byte-count byte, which is also acknowledged and thrown away.
4. Data bytes, which fill the register file from index 0 upward until the host issues STOP.

Two register pairs (11/12 and 13/14) are staged in a shadow buffer. They reach the live file at STOP, and only when both halves of the pair arrived in that transaction.

**Reads.** A read first returns a length byte, then registers 0 upward. Register 8 sets how many register bytes are valid. Any byte past that length, or past the end of the file, reads as all ones because the slave leaves SDA released. Both bus lines pass through a two-flop synchronizer. All protocol decisions are taken on the system clock, using the edges detected on the synchronized SCL.

Top module: `cfg_blkwr_slave`

## Requirements
- R1: The slave acknowledges the 8-bit addresses 0xD2 (write) and 0xD3 (read). For any other address it leaves the acknowledge bit high and ignores the rest of the transaction.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. Data byte n (n counted from 0) targets register n. Every data byte is acknowledged, including bytes whose index is above 20; those bytes change nothing.
- R3: A STOP after any complete byte ends the write. All bytes received before it are kept and visible on `regs_o`, with register i in bits [8i+7:8i].
- R4: A read returns the value of register 8 (N) first, then registers 0 to N-1 in order. Any further byte, and any index above 20, reads as 0xFF.
- R5: Register 8 resets to 0x08. A write of 0x00 to it leaves its previous value unchanged, so it is never zero.
- R6: Registers 11/12 form one pair and 13/14 another. A pair updates at STOP only if both of its bytes were written in that transaction; otherwise neither byte changes. Before the STOP, the live values of a pair stay at their old values.
- R7: After reset, register 7 holds 0x91 (upper nibble 1001), register 8 holds 0x08, and every other register holds 0x00. Register 7 is read-only.
- R8: When the host answers a read byte with a not-acknowledge (SDA high), the slave stops driving. It keeps SDA released until the next START or STOP.
- R9: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 168 | Live register file, register i in bits [8i+7:8i] |

## Verification
The bench goes after the following corner cases:

- **Paired registers.** It writes just one half of a pair, and it holds a complete pair open without a STOP. A design that committed pair bytes immediately, or one half at a time, would show torn values on `regs_o`.
- **Write lengths.** It uses writes that end after 3, 12, 13, 14 and 15 data bytes, and one that runs past index 20. A slave that dropped trailing bytes, or wrapped the index, would corrupt low registers.
- **Read length.** It reads with a length of 3 and clocks one byte beyond it; an off-by-one length would return a register instead of 0xFF.
- **Length register.** It writes zero to the length register. A design that accepted the zero would return no data on later reads.
- **Early not-acknowledge.** It clocks a byte after the host sends not-acknowledge. A slave that kept transmitting would pull SDA low and collide with the host.

// File: rtl/cfg_blkwr_slave.sv
module cfg_blkwr_slave #(
  parameter int NREG = 21,
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int LEN_IDX = 8,
  parameter int ID_IDX = 7,
  parameter logic [7:0] ID_VAL = 8'h91,
  parameter logic [7:0] LEN_RST = 8'h08,
  parameter int PAIR0 = 11,
  parameter int PAIR1 = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK, S_WAIT} st_t;

  logic [2:0] scl_sy, sda_sy;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, bytecnt;
  logic       addr_ph, rd, nack;
  logic [7:0] regs [NREG];
  logic [7:0] stg [4];
  logic [3:0] stg_v;
  logic [7:0] rd_sel, tx_nxt;

  wire scl_s = scl_sy[1];
  wire scl_q = scl_sy[2];
  wire sda_s = sda_sy[1];
  wire sda_q = sda_sy[2];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] rd_idx = bytecnt - 8'd1;
  wire [7:0] wr_idx = bytecnt - 8'd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  always_comb begin
    rd_sel = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == 8'(i)) rd_sel = regs[i];
  end

  assign tx_nxt = (bytecnt == 8'd0) ? regs[LEN_IDX] :
                  (rd_idx < regs[LEN_IDX]) ? rd_sel : 8'hFF;

  always_comb
    for (int i = 0; i < NREG; i++) regs_o[i*8 +: 8] = regs[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      bytecnt <= '0;
      addr_ph <= 1'b0;
      rd      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      stg_v   <= '0;
      for (int p = 0; p < 4; p++) stg[p] <= '0;
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == ID_IDX) ? ID_VAL : (i == LEN_IDX) ? LEN_RST : 8'h00;
    end else if (start_det) begin
      st      <= S_RX;
      bitcnt  <= '0;
      bytecnt <= '0;
      addr_ph <= 1'b1;
      sda_oe  <= 1'b0;
      stg_v   <= '0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      stg_v  <= '0;
      if (stg_v[1:0] == 2'b11) begin
        regs[PAIR0]   <= stg[0];
        regs[PAIR0+1] <= stg[1];
      end
      if (stg_v[3:2] == 2'b11) begin
        regs[PAIR1]   <= stg[2];
        regs[PAIR1+1] <= stg[3];
      end
    end else begin
      case (st)
        S_RX:
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (addr_ph) begin
              if (shreg[7:1] == SLV_ADDR) begin
                sda_oe <= 1'b1;
                rd     <= shreg[0];
                st     <= S_RACK;
              end else begin
                st <= S_WAIT;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= S_RACK;
              if (bytecnt != 8'hFF) bytecnt <= bytecnt + 8'd1;
              if (bytecnt >= 8'd2)
                for (int i = 0; i < NREG; i++)
                  if (wr_idx == 8'(i)) begin
                    if (i == PAIR0) begin
                      stg[0] <= shreg; stg_v[0] <= 1'b1;
                    end else if (i == PAIR0 + 1) begin
                      stg[1] <= shreg; stg_v[1] <= 1'b1;
                    end else if (i == PAIR1) begin
                      stg[2] <= shreg; stg_v[2] <= 1'b1;
                    end else if (i == PAIR1 + 1) begin
                      stg[3] <= shreg; stg_v[3] <= 1'b1;
                    end else if (!(i == ID_IDX || (i == LEN_IDX && shreg == 8'd0))) begin
                      regs[i] <= shreg;
                    end
                  end
            end
          end
        S_RACK:
          if (scl_fall) begin
            addr_ph <= 1'b0;
            bitcnt  <= '0;
            if (addr_ph && rd) begin
              shreg   <= tx_nxt;
              sda_oe  <= ~tx_nxt[7];
              bytecnt <= 8'd1;
              st      <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= S_TACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        S_TACK:
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              st <= S_WAIT;
            end else begin
              shreg  <= tx_nxt;
              sda_oe <= ~tx_nxt[7];
              bitcnt <= '0;
              st     <= S_TX;
              if (bytecnt != 8'hFF) bytecnt <= bytecnt + 8'd1;
            end
          end
        default: ;
      endcase
    end
endmodule

// File: rtl/cfg_blkwr_slave_chk.sv
module cfg_blkwr_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_s,
  input logic        stop_det,
  input logic [7:0]  len_b,
  input logic [7:0]  id_b,
  input logic [15:0] pair0_w,
  input logic [15:0] pair1_w
);
  // R9
  sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R5
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_b != 8'd0);
  // R7
  id_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(id_b));
  // R6
  pair0_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair0_w) |-> $past(stop_det));
  // R6
  pair1_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pair1_w) |-> $past(stop_det));
endmodule

bind cfg_blkwr_slave cfg_blkwr_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .len_b    (regs_o[LEN_IDX*8 +: 8]),
  .id_b     (regs_o[ID_IDX*8 +: 8]),
  .pair0_w  (regs_o[PAIR0*8 +: 16]),
  .pair1_w  (regs_o[PAIR1*8 +: 16])
);

// File: tb/cfg_blkwr_slave_test.sv
module cfg_blkwr_slave_test;
  localparam int NREG = 21;
  localparam int Q = 6;
  localparam logic [12:0] VEC [6] = '{
    {5'd3, 8'h10}, {5'd12, 8'h21}, {5'd13, 8'h42},
    {5'd14, 8'h63}, {5'd15, 8'h84}, {5'd23, 8'hC5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] rbuf [32];
  logic [7:0] rcnt;

  always #2 clk = ~clk;

  cfg_blkwr_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    wt; sda_m = 1'b1; wt; scl_m = 1'b1; wt; sda_m = 1'b0; wt; scl_m = 1'b0;
  endtask

  task automatic i2c_stop;
    wt; sda_m = 1'b0; wt; scl_m = 1'b1; wt; sda_m = 1'b1; wt; wt;
  endtask

  task automatic bit_out(input logic v);
    wt; sda_m = v; wt; scl_m = 1'b1; wt; wt; scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic v);
    wt; sda_m = 1'b1; wt; scl_m = 1'b1; wt; v = sda_line; wt; scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackb);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ackb);
  endtask

  task automatic recv_byte(input logic ackv, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(ackv);
  endtask

  function automatic logic [7:0] wval(input logic [7:0] seed, input int i, input logic [7:0] b8);
    return (i == 8) ? b8 : seed + 8'(i * 29);
  endfunction

  function automatic logic [NREG*8-1:0] model_vec();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic model_apply(input int len, input logic [7:0] seed, input logic [7:0] b8);
    for (int i = 0; i < len && i < NREG; i++) begin
      logic [7:0] v = wval(seed, i, b8);
      if (i >= 11 && i <= 14) continue;
      if (i == 7) continue;
      if (i == 8 && v == 8'd0) continue;
      model[i] = v;
    end
    if (len >= 13) begin model[11] = wval(seed, 11, b8); model[12] = wval(seed, 12, b8); end
    if (len >= 15) begin model[13] = wval(seed, 13, b8); model[14] = wval(seed, 14, b8); end
  endtask

  task automatic wr_txn(input int len, input logic [7:0] seed, input logic [7:0] b8, input bit do_stop);
    logic a;
    logic bad = 1'b0;
    i2c_start;
    send_byte(8'hD2, a); bad |= a;
    send_byte(8'hA5, a); bad |= a;
    send_byte(8'h3C, a); bad |= a;
    for (int i = 0; i < len; i++) begin
      send_byte(wval(seed, i, b8), a);
      bad |= a;
    end
    chk(!bad, "R2 R1 write acknowledges", 192'(bad), 0);
    if (do_stop) begin
      i2c_stop;
      model_apply(len, seed, b8);
    end
  endtask

  task automatic rd_txn(input int n, input int nack_pos);
    logic a;
    i2c_start;
    send_byte(8'hD3, a);
    chk(!a, "R1 read address ack", 192'(a), 0);
    recv_byte(1'b0, rcnt);
    for (int k = 0; k < n; k++)
      recv_byte((k == n - 1) || (k == nack_pos), rbuf[k]);
    i2c_stop;
  endtask

  task automatic rd_compare(input string tag);
    int n = int'(model[8]);
    logic bad = 1'b0;
    rd_txn(n, -1);
    chk(rcnt == model[8], {tag, " length byte"}, 192'(rcnt), 192'(model[8]));
    for (int k = 0; k < n; k++)
      if (rbuf[k] != ((k < NREG) ? model[k] : 8'hFF)) bad = 1'b1;
    chk(!bad, {tag, " read data"}, 192'(bad), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    model[7] = 8'h91;
    model[8] = 8'h08;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7 defaults, R5 length default
    chk(regs_o == model_vec(), "R7 reset register file", 192'(regs_o), 192'(model_vec()));
    chk(regs_o[8*8 +: 8] == 8'h08, "R5 length reset", 192'(regs_o[8*8 +: 8]), 8);
    chk(sda_oe == 1'b0, "R9 idle release", 192'(sda_oe), 0);

    // R1 foreign address
    i2c_start;
    send_byte(8'hA4, a);
    i2c_stop;
    chk(a == 1'b1, "R1 foreign address not acked", 192'(a), 1);
    chk(regs_o == model_vec(), "R1 foreign address no effect", 192'(regs_o), 192'(model_vec()));

    // table of write lengths and seeds: R2 R3 R6 R4
    for (int v = 0; v < 6; v++) begin
      wr_txn(int'(VEC[v][12:8]), VEC[v][7:0], 8'd21, 1'b1);
      chk(regs_o == model_vec(), "R3 R2 R6 register file after stop", 192'(regs_o), 192'(model_vec()));
      rd_compare("R4");
    end

    // R7 register 7 read-only
    chk(regs_o[7*8 +: 8] == 8'h91, "R7 id register", 192'(regs_o[7*8 +: 8]), 8'h91);

    // R5 zero length write ignored
    wr_txn(9, 8'h33, 8'h00, 1'b1);
    chk(regs_o[8*8 +: 8] == 8'd21, "R5 zero length ignored", 192'(regs_o[8*8 +: 8]), 21);
    chk(regs_o == model_vec(), "R5 register file", 192'(regs_o), 192'(model_vec()));

    // R6 pair held until stop
    wr_txn(15, 8'h5A, 8'd21, 1'b0);
    repeat (20) @(negedge clk);
    chk(regs_o[11*8 +: 32] == {model[14], model[13], model[12], model[11]},
        "R6 pairs held before stop", 192'(regs_o[11*8 +: 32]),
        192'({model[14], model[13], model[12], model[11]}));
    i2c_stop;
    model_apply(15, 8'h5A, 8'd21);
    chk(regs_o == model_vec(), "R6 pairs after stop", 192'(regs_o), 192'(model_vec()));

    // R4 short read length plus one byte past it
    wr_txn(9, 8'h70, 8'd3, 1'b1);
    rd_txn(4, -1);
    chk(rcnt == 8'd3, "R4 length byte 3", 192'(rcnt), 3);
    chk({rbuf[0], rbuf[1], rbuf[2]} == {model[0], model[1], model[2]}, "R4 first three",
        192'({rbuf[0], rbuf[1], rbuf[2]}), 192'({model[0], model[1], model[2]}));
    chk(rbuf[3] == 8'hFF, "R4 past length", 192'(rbuf[3]), 8'hFF);

    // R8 host not-acknowledge releases the line
    rd_txn(2, 0);
    chk(rbuf[0] == model[0], "R8 byte before nack", 192'(rbuf[0]), 192'(model[0]));
    chk(rbuf[1] == 8'hFF, "R8 released after nack", 192'(rbuf[1]), 8'hFF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule